// File: doc/BRIEF.md
# Dual-Mode SIMD Multiply-Accumulate Unit

This coprocessor datapath keeps one signed 40-bit accumulator and folds products of two 32-bit operands into it. A host issues commands on a valid/ready port carrying a 3-bit opcode, a 2-bit half selector and two 32-bit operands. Three commands multiply and accumulate. The first multiplies one chosen 16-bit half of each operand. The second multiplies both pairs of packed 16-bit halves and adds both products at once. The third forms a full 32x32 signed product and keeps only its low 40 bits. Two more commands move the accumulator: one reads it out as a pair of 32-bit words, the other loads it from a pair of words.

Operand `cmd_a` is the multiplier and `cmd_b` is the multiplicand. When the multiplier of a 32x32 command is a sign-extended 16-bit value, the unit finishes that command in the cycle it is accepted. Any other 32x32 command goes to a short iterative engine, and `cmd_ready` stays low until the engine has committed its result. Commands always take effect in the order they were accepted.

Top module: `mac_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, the accumulator is zero, `cmd_ready` is 1 and `rd_valid` is 0.
- R2: Opcode 0 accumulates the 32-bit signed product of one half of each operand. `cmd_sel[1]` picks the half of `cmd_a` (1 = bits 31:16, 0 = bits 15:0). `cmd_sel[0]` picks the half of `cmd_b` in the same way.
- R3: Opcode 1 multiplies the upper half of `cmd_a` by the upper half of `cmd_b`, and the lower half of `cmd_a` by the lower half of `cmd_b`, all signed. It sign-extends both products to 40 bits and adds both to the accumulator in one command.
- R4: Opcode 2 adds the low 40 bits of the signed 64-bit product `cmd_a` x `cmd_b` to the accumulator.
- R5: Every accumulation wraps modulo 2^40. There is no saturation.
- R6: Opcode 3 leaves the accumulator unchanged. In the cycle after it is accepted, `rd_valid` is 1 for exactly one cycle. In that cycle `rd_lo` holds accumulator bits 31:0 and `rd_hi` holds bits 39:32 sign-extended to 32 bits. The value read includes every earlier command and no later one.
- R7: Opcode 4 loads the accumulator with `cmd_b[7:0]` as bits 39:32 and `cmd_a` as bits 31:0. Bits 31:8 of `cmd_b` are ignored.
- R8: Opcodes 0, 1, 3 and 4 take one cycle, so `cmd_ready` stays 1. Opcode 2 also takes one cycle when `cmd_a[31:16]` all equal `cmd_a[15]`. Otherwise `cmd_ready` is 0 for the three cycles after acceptance, and the result is added at the third of those clock edges.
- R9: Opcodes 5, 6 and 7 are accepted and have no effect on the accumulator or on the read port.
- R10: A command is taken only on a clock edge where both `cmd_valid` and `cmd_ready` are 1. A command held while `cmd_ready` is 0 is taken once `cmd_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 3 | Opcode (0 half MAC, 1 dual MAC, 2 wide MAC, 3 read, 4 load) |
| cmd_sel | input | 2 | Half selector for opcode 0 |
| cmd_a | input | 32 | Multiplier, or low word for load |
| cmd_b | input | 32 | Multiplicand, or high word for load |
| rd_valid | output | 1 | Read result valid pulse |
| rd_lo | output | 32 | Accumulator bits 31:0 |
| rd_hi | output | 32 | Accumulator bits 39:32, sign-extended |

## Verification
Two pieces of work can meet on one clock edge. The first is a read presenting its data while the next command is already updating the accumulator. The bench issues a read and then an accumulate on the very next edge, and requires the read data to show the value from before the accumulate. The second is the commit of a stalled wide multiply on the same edge that `cmd_ready` returns and a held command waits. The bench keeps `cmd_valid` high through the stall and judges every cycle against a behavioural model. In that model the held command is taken only on the edge after the commit, and its effect lands on top of the committed product.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam logic [2:0] OPC_MAC16  = 3'd0;
    localparam logic [2:0] OPC_MACDUO = 3'd1;
    localparam logic [2:0] OPC_MAC32  = 3'd2;
    localparam logic [2:0] OPC_RDOUT  = 3'd3;
    localparam logic [2:0] OPC_LOADIN = 3'd4;
endpackage

// File: rtl/mac_half_mul.sv
module mac_half_mul #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] mul_x,
    input  logic [WORD_W-1:0] mul_y,
    input  logic              pick_x_hi,
    input  logic              pick_y_hi,
    output logic [WORD_W-1:0] prod
);
    localparam int HALF_W = WORD_W / 2;

    logic signed [HALF_W-1:0] opx;
    logic signed [HALF_W-1:0] opy;
    logic signed [WORD_W-1:0] p;

    always_comb begin
        opx  = pick_x_hi ? mul_x[WORD_W-1:HALF_W] : mul_x[HALF_W-1:0];
        opy  = pick_y_hi ? mul_y[WORD_W-1:HALF_W] : mul_y[HALF_W-1:0];
        p    = opx * opy;
        prod = p;
    end
endmodule

// File: rtl/mac_wide_engine.sv
module mac_wide_engine #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] mr,
    input  logic [WORD_W-1:0] md,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  prod
);
    localparam int HALF_W = WORD_W / 2;
    localparam int PP_W   = WORD_W + HALF_W;

    typedef struct packed {
        logic [1:0]        cnt;
        logic [WORD_W-1:0] mr;
        logic [WORD_W-1:0] md;
        logic [ACC_W-1:0]  part;
    } eng_t;

    eng_t eng_d, eng_q;
    logic signed [PP_W-1:0] lo_pp;
    logic signed [PP_W-1:0] hi_pp;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        lo_pp = $signed(eng_q.md) * $signed({1'b0, eng_q.mr[HALF_W-1:0]});
        hi_pp = $signed(eng_q.md) * $signed(eng_q.mr[WORD_W-1:HALF_W]);
        case (eng_q.cnt)
            2'd3: begin
                eng_d.part = lo_pp[ACC_W-1:0];
                eng_d.cnt  = 2'd2;
            end
            2'd2: begin
                eng_d.part = eng_q.part + {hi_pp[ACC_W-HALF_W-1:0], {HALF_W{1'b0}}};
                eng_d.cnt  = 2'd1;
            end
            2'd1: begin
                done      = 1'b1;
                eng_d.cnt = 2'd0;
            end
            default: begin
                if (start) begin
                    eng_d.cnt  = 2'd3;
                    eng_d.mr   = mr;
                    eng_d.md   = md;
                    eng_d.part = '0;
                end
            end
        endcase
        busy = (eng_q.cnt != 2'd0);
        prod = eng_q.part;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    // R8
    eng_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.cnt != 2'd0) |=> (eng_q.cnt == $past(eng_q.cnt) - 2'd1));

    // R8
    eng_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && eng_q.cnt == 2'd0) |=> (eng_q.cnt == 2'd3));
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_sel,
    input  logic [WORD_W-1:0] cmd_a,
    input  logic [WORD_W-1:0] cmd_b,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi
);
    import mac_pkg::*;

    localparam int HALF_W = WORD_W / 2;
    localparam int TOP_W  = ACC_W - WORD_W;
    localparam int PP_W   = WORD_W + HALF_W;
    localparam int LANES  = 2;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic              rd_v;
        logic [WORD_W-1:0] rd_lo;
        logic [WORD_W-1:0] rd_hi;
    } unit_t;

    unit_t st_d, st_q;

    logic                     accept;
    logic                     dual;
    logic                     fits16;
    logic                     eng_start;
    logic                     eng_busy;
    logic                     eng_done;
    logic [ACC_W-1:0]         eng_prod;
    logic [WORD_W-1:0]        lane_p  [LANES];
    logic [ACC_W-1:0]         lane_ext[LANES];
    logic signed [PP_W-1:0]   fast_pp;

    assign dual = (cmd_op == OPC_MACDUO);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic sx, sy;
        if (g == 0) begin : g_first
            assign sx = dual ? 1'b1 : cmd_sel[1];
            assign sy = dual ? 1'b1 : cmd_sel[0];
        end else begin : g_other
            assign sx = 1'b0;
            assign sy = 1'b0;
        end
        mac_half_mul #(.WORD_W(WORD_W)) u_mul (
            .mul_x     (cmd_a),
            .mul_y     (cmd_b),
            .pick_x_hi (sx),
            .pick_y_hi (sy),
            .prod      (lane_p[g])
        );
        assign lane_ext[g] = {{TOP_W{lane_p[g][WORD_W-1]}}, lane_p[g]};
    end

    mac_wide_engine #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .mr    (cmd_a),
        .md    (cmd_b),
        .busy  (eng_busy),
        .done  (eng_done),
        .prod  (eng_prod)
    );

    always_comb begin
        cmd_ready = !eng_busy;
        accept    = cmd_valid && cmd_ready;
        fits16    = (cmd_a[WORD_W-1:HALF_W] == {HALF_W{cmd_a[HALF_W-1]}});
        eng_start = accept && (cmd_op == OPC_MAC32) && !fits16;
        fast_pp   = $signed(cmd_b) * $signed(cmd_a[HALF_W-1:0]);

        st_d      = st_q;
        st_d.rd_v = 1'b0;
        if (eng_done) begin
            st_d.acc = st_q.acc + eng_prod;
        end else if (accept) begin
            case (cmd_op)
                OPC_MAC16:  st_d.acc = st_q.acc + lane_ext[0];
                OPC_MACDUO: st_d.acc = st_q.acc + lane_ext[0] + lane_ext[1];
                OPC_MAC32: begin
                    if (fits16) st_d.acc = st_q.acc + fast_pp[ACC_W-1:0];
                end
                OPC_RDOUT: begin
                    st_d.rd_v  = 1'b1;
                    st_d.rd_lo = st_q.acc[WORD_W-1:0];
                    st_d.rd_hi = {{(2*WORD_W-ACC_W){st_q.acc[ACC_W-1]}},
                                  st_q.acc[ACC_W-1:WORD_W]};
                end
                OPC_LOADIN: st_d.acc = {cmd_b[TOP_W-1:0], cmd_a};
                default: ;
            endcase
        end
        rd_valid = st_q.rd_v;
        rd_lo    = st_q.rd_lo;
        rd_hi    = st_q.rd_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    long_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OPC_MAC32 && !fits16) |=> !cmd_ready);

    // R8
    short_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op != OPC_MAC32) |=> cmd_ready);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(accept && cmd_op == OPC_RDOUT));

    // R6
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OPC_RDOUT) |=> $stable(st_q.acc));

    // R6
    rd_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_hi[WORD_W-1:TOP_W] == {(WORD_W-TOP_W){rd_hi[TOP_W-1]}}));

    // R9
    spare_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op > OPC_LOADIN) |=> ($stable(st_q.acc) && !rd_valid));
endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_sel = 2'd0;
    logic [31:0] cmd_a = '0;
    logic [31:0] cmd_b = '0;
    logic        rd_valid;
    logic [31:0] rd_lo, rd_hi;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    // behavioural reference
    logic [39:0] m_acc;
    logic [39:0] m_pend;
    int          m_busy;
    bit          m_took;
    bit          m_rdv;
    logic [31:0] m_lo, m_hi;

    function automatic logic [39:0] mul16(input logic [15:0] x, input logic [15:0] y);
        longint t;
        t = longint'($signed(x)) * longint'($signed(y));
        return t[39:0];
    endfunction

    function automatic logic [39:0] mul32(input logic [31:0] x, input logic [31:0] y);
        longint t;
        t = longint'($signed(x)) * longint'($signed(y));
        return t[39:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_pend = '0; m_busy = 0; m_took = 0;
            m_rdv = 0; m_lo = '0; m_hi = '0;
        end else begin
            m_took = 0;
            m_rdv  = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) m_acc = m_acc + m_pend;
            end else if (cmd_valid) begin
                m_took = 1;
                case (cmd_op)
                    3'd0: m_acc = m_acc + mul16(cmd_sel[1] ? cmd_a[31:16] : cmd_a[15:0],
                                                cmd_sel[0] ? cmd_b[31:16] : cmd_b[15:0]);
                    3'd1: m_acc = m_acc + mul16(cmd_a[31:16], cmd_b[31:16])
                                        + mul16(cmd_a[15:0], cmd_b[15:0]);
                    3'd2: begin
                        if ($signed(cmd_a) >= -32768 && $signed(cmd_a) <= 32767)
                            m_acc = m_acc + mul32(cmd_a, cmd_b);
                        else begin
                            m_pend = mul32(cmd_a, cmd_b);
                            m_busy = 3;
                        end
                    end
                    3'd3: begin
                        m_rdv = 1;
                        m_lo  = m_acc[31:0];
                        m_hi  = {{24{m_acc[39]}}, m_acc[39:32]};
                    end
                    3'd4: m_acc = {cmd_b[7:0], cmd_a};
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (cmd_ready !== (m_busy == 0)) begin
                fails++;
                $display("FAIL R8 ready: got %0b expected %0b", cmd_ready, (m_busy == 0));
            end
            vectors++;
            if (rd_valid !== m_rdv) begin
                fails++;
                $display("FAIL R6 rd_valid: got %0b expected %0b", rd_valid, m_rdv);
            end
            if (m_rdv) begin
                vectors++;
                if (rd_lo !== m_lo || rd_hi !== m_hi) begin
                    fails++;
                    $display("FAIL R6 read data: got %h_%h expected %h_%h", rd_hi, rd_lo, m_hi, m_lo);
                end
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [1:0] sel,
                         input logic [31:0] a, input logic [31:0] b);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_a = a; cmd_b = b;
        do begin
            @(posedge clk); #1;
        end while (!m_took);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_check(input logic [31:0] ehi, input logic [31:0] elo, input string tag);
        issue(3'd3, 2'd0, '0, '0);
        vectors++;
        if (rd_valid !== 1'b1 || rd_hi !== ehi || rd_lo !== elo) begin
            fails++;
            $display("FAIL %s: got v=%0b %h_%h expected v=1 %h_%h", tag, rd_valid, rd_hi, rd_lo, ehi, elo);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        vectors++;
        if (cmd_ready !== 1'b1 || rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: got ready=%0b rdv=%0b expected 1 0", cmd_ready, rd_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        read_check(32'h0, 32'h0, "R1 accumulator after reset");

        // R2 half selection, all four combinations
        issue(3'd4, 2'd0, 32'h0, 32'h0);
        issue(3'd0, 2'b00, 32'h0003_FFFE, 32'h0005_0007);
        read_check(32'hFFFF_FFFF, 32'hFFFF_FFF2, "R2 low/low");
        issue(3'd0, 2'b11, 32'h0003_FFFE, 32'h0005_0007);
        issue(3'd0, 2'b10, 32'h0003_FFFE, 32'h0005_0007);
        issue(3'd0, 2'b01, 32'h0003_FFFE, 32'h0005_0007);
        read_check(32'h0, 32'h0000_000C, "R2 mixed halves");

        // R3 dual lanes
        issue(3'd4, 2'd0, 32'h0, 32'h0);
        issue(3'd1, 2'd0, 32'h8000_8000, 32'h8000_7FFF);
        read_check(32'h0, 32'h0000_8000, "R3 dual lanes");

        // R4 wide truncated product, long path
        issue(3'd4, 2'd0, 32'h0, 32'h0);
        issue(3'd2, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        read_check(32'hFFFF_FFFF, 32'h0000_0001, "R4 wide product");

        // R8 wide with short multiplier
        issue(3'd4, 2'd0, 32'h0, 32'h0);
        issue(3'd2, 2'd0, 32'hFFFF_FFFD, 32'h0001_0000);
        read_check(32'hFFFF_FFFF, 32'hFFFD_0000, "R8 fast wide path");

        // R5 wrap past the positive limit
        issue(3'd4, 2'd0, 32'hFFFF_FFFF, 32'h0000_007F);
        issue(3'd0, 2'b00, 32'h1, 32'h1);
        read_check(32'hFFFF_FF80, 32'h0000_0000, "R5 wrap");

        // R7 load ignores upper bits of high word
        issue(3'd4, 2'd0, 32'h1122_3344, 32'hABCD_EF12);
        read_check(32'h0000_0012, 32'h1122_3344, "R7 load");

        // R9 spare opcodes
        issue(3'd5, 2'd3, 32'h1234, 32'h1234);
        issue(3'd6, 2'd3, 32'h1234, 32'h1234);
        issue(3'd7, 2'd3, 32'h1234, 32'h1234);
        vectors++;
        if (rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 spare op read: got %0b expected 0", rd_valid);
        end
        read_check(32'h0000_0012, 32'h1122_3344, "R9 spare opcodes");

        // R6 read followed at once by accumulate: read shows old value
        issue(3'd4, 2'd0, 32'h100, 32'h0);
        issue(3'd3, 2'd0, '0, '0);
        vectors++;
        if (rd_lo !== 32'h100 || rd_hi !== 32'h0) begin
            fails++;
            $display("FAIL R6 back-to-back: got %h_%h expected 0_100", rd_hi, rd_lo);
        end
        issue(3'd0, 2'b00, 32'h2, 32'h3);
        read_check(32'h0, 32'h0000_0106, "R6 after accumulate");

        // R10 command held through stall, taken after commit
        issue(3'd4, 2'd0, 32'h0, 32'h0);
        issue(3'd2, 2'd0, 32'h0001_0000, 32'h0000_0010);
        issue(3'd1, 2'd0, 32'h0001_0001, 32'h0002_0002);
        read_check(32'h0, 32'h0010_0004, "R10 held command");

        // mixed random traffic, judged every clock by the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if ($urandom % 2) ra = {{16{ra[15]}}, ra[15:0]};
            issue(3'($urandom % 8), 2'($urandom % 4), ra, rb);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule